// File: doc/BRIEF.md
# VPS Biphase Payload Decoder

This block takes the already-sliced raw bytes of one VPS data line and turns them into the decoded data record. Every raw byte carries four data bits, and each bit is sent as a complementary pair of line bits. The block collapses each raw byte to one nibble and joins consecutive nibbles into data bytes. It also checks every bit pair for a coding violation.

A record is opened with `start_i`. The next 26 bytes strobed with `in_valid_i` are consumed. One decoded byte, with its index, appears after each second raw byte. After the last byte a one-cycle `done_o` pulse marks the end of the record. `error_o` then gives the OR of every coding violation seen in the record. Clock recovery and line framing happen upstream.

Top module: `vps_biphase_decoder`

## Requirements
- R1: An open record consumes exactly 26 strobed bytes (2 x OUT_BYTES), counted from 0 at the start; after the 26th the record closes.
- R2: `done_o` is a one-cycle pulse one clock after the edge that accepts raw byte 25. It coincides with the output byte whose `out_idx_o` is 12.
- R3: Output byte k is `{nibble(raw 2k), nibble(raw 2k+1)}`, so the earlier byte forms the high nibble. It is presented with `out_valid_o` high for one cycle, one clock after raw byte 2k+1 is accepted, with `out_idx_o` = k.
- R4: Nibble bit g equals raw bit 2g+1. Raw bits 7,5,3,1 give nibble bits 3,2,1,0, so `10` decodes to 1 and `01` to 0.
- R5: A bit pair (raw bit 2g+1, raw bit 2g) with equal bits (`00` or `11`) is a violation. `error_o` is set at `done_o` to the OR of violations over all 26 bytes and holds until the next `done_o`.
- R6: `start_i` discards any partial record, including a held high nibble, and clears the violation accumulator. A byte strobed in the same cycle as `start_i` is raw byte 0.
- R7: Bytes strobed while no record is open, whether before any start or after the 26th byte, are ignored: they raise neither `out_valid_o` nor `done_o`.
- R8: Cycles with `in_valid_i` low inside a record neither advance the record nor emit output.
- R9: After reset `out_valid_o`, `done_o` and `error_o` are 0 and no record is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new record |
| in_valid_i | input | 1 | Raw byte strobe |
| in_byte_i | input | 8 | Raw biphase-coded byte |
| out_valid_o | output | 1 | Decoded byte strobe |
| out_byte_o | output | 8 | Decoded data byte |
| out_idx_o | output | 4 | Index of decoded byte in the record |
| done_o | output | 1 | Record complete pulse |
| error_o | output | 1 | Violation seen in the last completed record |

## Verification
Twenty clean records step the decoded values through all 256 byte values. Each nibble arrangement is therefore seen in both the high and the low half, which would expose swapped halves or a wrong bit in a pair. A sweep then puts a single `00` or `11` pair at every pair position of every raw byte. This shows that each of the 208 violation sites reaches the record flag, and that the data bit is still taken from the upper bit. Further patterns cover strobes outside a record, idle gaps, a start inside a record, a start that shares a cycle with the first byte, and a start with a half-filled byte. These tell the counting, discard and ignore rules apart.

// File: rtl/vpsd_pkg.sv
package vpsd_pkg;

    localparam int VPSD_NIB_W     = 4;
    localparam int VPSD_OUT_BYTES = 13;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } half_e;

    typedef struct packed {
        half_e half;
        logic  last;
    } slot_t;

    function automatic logic pair_bad(input logic [1:0] p);
        return p[1] == p[0];
    endfunction

    function automatic logic pair_bit(input logic [1:0] p);
        return p[1];
    endfunction

endpackage

// File: rtl/vpsd_symbol.sv
module vpsd_symbol
    import vpsd_pkg::*;
#(
    parameter int NIB_W = VPSD_NIB_W,
    localparam int RAW_W = 2 * NIB_W
) (
    input  logic [RAW_W-1:0] raw_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             bad_o
);

    logic [NIB_W-1:0] bad_vec;

    for (genvar g = 0; g < NIB_W; g++) begin : g_pair
        assign nib_o[g]   = pair_bit(raw_i[2*g+1 -: 2]);
        assign bad_vec[g] = pair_bad(raw_i[2*g+1 -: 2]);
    end

    assign bad_o = |bad_vec;

endmodule

// File: rtl/vpsd_tracker.sv
module vpsd_tracker
    import vpsd_pkg::*;
#(
    parameter int RAW_BYTES = 2 * VPSD_OUT_BYTES,
    localparam int CNT_W = $clog2(RAW_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             sym_bad_i,
    output logic             take_o,
    output slot_t            slot_o,
    output logic [CNT_W-1:0] pos_o,
    output logic             rec_err_o
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(RAW_BYTES - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    assign pos_o       = start_i ? '0 : cnt_q;
    assign take_o      = valid_i & (active_q | start_i);
    assign rec_err_o   = (start_i ? 1'b0 : err_q) | sym_bad_i;
    assign slot_o.half = pos_o[0] ? PH_LOW : PH_HIGH;
    assign slot_o.last = (pos_o == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            err_q    <= 1'b0;
        end else if (take_o) begin
            if (slot_o.last) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
                err_q    <= 1'b0;
            end else begin
                active_q <= 1'b1;
                cnt_q    <= pos_o + CNT_W'(1);
                err_q    <= rec_err_o;
            end
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            err_q    <= 1'b0;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_POS);  // R1

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> cnt_q == '0);  // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        active_q && $past(active_q) && $past(err_q) && !$past(start_i) |-> err_q);  // R5

endmodule

// File: rtl/vpsd_assembler.sv
module vpsd_assembler
    import vpsd_pkg::*;
#(
    parameter int NIB_W = VPSD_NIB_W,
    parameter int IDX_W = 4,
    localparam int OUT_W = 2 * NIB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  slot_t            slot_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             rec_err_i,
    output logic             out_valid_o,
    output logic [OUT_W-1:0] out_byte_o,
    output logic [IDX_W-1:0] out_idx_o,
    output logic             done_o,
    output logic             error_o
);

    logic [NIB_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q        <= '0;
            out_valid_o <= 1'b0;
            out_byte_o  <= '0;
            out_idx_o   <= '0;
            done_o      <= 1'b0;
            error_o     <= 1'b0;
        end else begin
            out_valid_o <= 1'b0;
            done_o      <= 1'b0;
            if (take_i) begin
                if (slot_i.half == PH_HIGH) begin
                    hi_q <= nib_i;
                end else begin
                    out_byte_o  <= {hi_q, nib_i};
                    out_idx_o   <= idx_i;
                    out_valid_o <= 1'b1;
                end
                if (slot_i.last) begin
                    done_o  <= 1'b1;
                    error_o <= rec_err_i;
                end
            end
        end
    end

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(error_o));  // R5

endmodule

// File: rtl/vps_biphase_decoder.sv
module vps_biphase_decoder
    import vpsd_pkg::*;
#(
    parameter int NIB_W     = VPSD_NIB_W,
    parameter int OUT_BYTES = VPSD_OUT_BYTES,
    localparam int RAW_BYTES = 2 * OUT_BYTES,
    localparam int CNT_W     = $clog2(RAW_BYTES),
    localparam int IDX_W     = CNT_W - 1,
    localparam int BYTE_W    = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_byte_i,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic [IDX_W-1:0]  out_idx_o,
    output logic              done_o,
    output logic              error_o
);

    logic             take;
    slot_t            slot;
    logic [CNT_W-1:0] pos;
    logic             rec_err;
    logic [NIB_W-1:0] nib;
    logic             sym_bad;

    vpsd_symbol #(.NIB_W(NIB_W)) u_symbol (
        .raw_i (in_byte_i),
        .nib_o (nib),
        .bad_o (sym_bad)
    );

    vpsd_tracker #(.RAW_BYTES(RAW_BYTES)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .valid_i   (in_valid_i),
        .sym_bad_i (sym_bad),
        .take_o    (take),
        .slot_o    (slot),
        .pos_o     (pos),
        .rec_err_o (rec_err)
    );

    vpsd_assembler #(.NIB_W(NIB_W), .IDX_W(IDX_W)) u_assembler (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take),
        .slot_i      (slot),
        .idx_i       (pos[CNT_W-1:1]),
        .nib_i       (nib),
        .rec_err_i   (rec_err),
        .out_valid_o (out_valid_o),
        .out_byte_o  (out_byte_o),
        .out_idx_o   (out_idx_o),
        .done_o      (done_o),
        .error_o     (error_o)
    );

    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
        done_o |-> out_valid_o && out_idx_o == IDX_W'(OUT_BYTES - 1));  // R2

    AST_OUT_SPACED: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |=> !out_valid_o);  // R3

    AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> $past(in_valid_i));  // R8

endmodule

// File: tb/vps_biphase_decoder_tb.sv
`timescale 1ns/1ps
module vps_biphase_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_byte_i = 8'h00;
    logic       out_valid_o;
    logic [7:0] out_byte_o;
    logic [3:0] out_idx_o;
    logic       done_o;
    logic       error_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string tag = "R9";

    // bench model state, built from the requirements
    bit       m_active = 1'b0;
    int       m_cnt = 0;
    bit       m_err = 1'b0;
    bit       m_err_out = 1'b0;
    bit [3:0] m_hi = 4'h0;
    logic [7:0] rec [26];

    always #10 clk = ~clk;

    vps_biphase_decoder dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_byte_i(in_byte_i), .out_valid_o(out_valid_o), .out_byte_o(out_byte_o),
        .out_idx_o(out_idx_o), .done_o(done_o), .error_o(error_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [3:0] n);
        logic [7:0] r;
        for (int g = 0; g < 4; g++) r[2*g+1 -: 2] = n[g] ? 2'b10 : 2'b01;
        return r;
    endfunction

    // one cycle: drive at negedge, sample at the following negedge
    task automatic feed(input bit v, input logic [7:0] b, input bit s);
        bit       exp_ov = 0, exp_done = 0, tk, acc, e;
        int       pos;
        logic [3:0] nib;
        logic [7:0] exp_byte = 0;
        int       exp_idx = 0;
        start_i = s; in_valid_i = v; in_byte_i = b;
        tk  = v && (m_active || s);
        pos = s ? 0 : m_cnt;
        acc = s ? 1'b0 : m_err;
        if (s) begin m_active = 1; m_cnt = 0; m_err = 0; end
        if (tk) begin
            nib = {b[7], b[5], b[3], b[1]};
            e = (b[7] == b[6]) || (b[5] == b[4]) || (b[3] == b[2]) || (b[1] == b[0]);
            acc = acc | e;
            if (pos % 2 == 0) m_hi = nib;
            else begin exp_ov = 1; exp_byte = {m_hi, nib}; exp_idx = pos / 2; end
            if (pos == 25) begin
                exp_done = 1; m_err_out = acc; m_active = 0; m_cnt = 0; m_err = 0;
            end else begin
                m_cnt = pos + 1; m_err = acc; m_active = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        start_i = 0; in_valid_i = 0;
        check(out_valid_o == exp_ov, tag, 32'(out_valid_o), 32'(exp_ov));
        if (exp_ov) begin
            check(out_byte_o == exp_byte, "R3 R4 byte", 32'(out_byte_o), 32'(exp_byte));
            check(out_idx_o == 4'(exp_idx), "R3 index", 32'(out_idx_o), 32'(exp_idx));
        end
        check(done_o == exp_done, "R2 done", 32'(done_o), 32'(exp_done));
        check(error_o == m_err_out, "R5 error", 32'(error_o), 32'(m_err_out));
    endtask

    // send rec[] as one record; sep=1 gives start its own cycle; gap inserts idle cycles
    task automatic send_record(input bit sep, input int gap_mod);
        if (sep) feed(0, 8'h00, 1);
        for (int j = 0; j < 26; j++) begin
            feed(1, rec[j], (!sep) && j == 0);
            if (gap_mod > 0 && (j % gap_mod) == 0) feed(0, 8'hFF, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state
        check(out_valid_o == 0, "R9 valid", 32'(out_valid_o), 0);
        check(done_o == 0, "R9 done", 32'(done_o), 0);
        check(error_o == 0, "R9 error", 32'(error_o), 0);

        // R7: strobes before any start are ignored
        tag = "R7 before start";
        for (int j = 0; j < 30; j++) feed(1, enc(4'(j)), 0);

        // R1: clean records sweeping every byte value through both nibble halves
        tag = "R1 clean";
        for (int r = 0; r < 20; r++) begin
            for (int j = 0; j < 26; j++) begin
                logic [7:0] d;
                d = 8'((r * 13 + j / 2) % 256);
                rec[j] = (j % 2 == 0) ? enc(d[7:4]) : enc(d[3:0]);
            end
            send_record(r[0], (r % 3 == 2) ? 5 : 0);
        end

        // R7: strobes after the 26th byte are ignored
        tag = "R7 after record";
        for (int j = 0; j < 6; j++) feed(1, 8'h00, 0);

        // R5: single violation at every pair of every byte, both kinds
        tag = "R5 violation";
        for (int p = 0; p < 26; p++)
            for (int g = 0; g < 4; g++)
                for (int k = 0; k < 2; k++) begin
                    for (int j = 0; j < 26; j++) rec[j] = enc(4'((j * 7 + p) % 16));
                    rec[p][2*g+1 -: 2] = k[0] ? 2'b11 : 2'b00;
                    send_record(0, 0);
                    feed(0, 8'h00, 0);
                end

        // R6: a start discards a partial record with a violation
        tag = "R6 restart";
        feed(1, 8'h00, 1);
        for (int j = 1; j < 9; j++) feed(1, enc(4'(j)), 0);
        for (int j = 0; j < 26; j++) rec[j] = enc(4'(15 - (j % 16)));
        send_record(0, 0);
        // R6: start while a high nibble is held, byte in the same cycle is byte 0
        feed(1, enc(4'hA), 1);
        feed(1, enc(4'h5), 0);
        feed(1, enc(4'h3), 0);
        for (int j = 0; j < 26; j++) rec[j] = enc(4'(j % 16));
        send_record(0, 0);
        // R6: separate start cycle after a partial record
        feed(1, enc(4'h1), 1);
        send_record(1, 0);

        // R8: idle cycles between every byte
        tag = "R8 gaps";
        for (int j = 0; j < 26; j++) rec[j] = enc(4'((j * 5) % 16));
        send_record(1, 1);
        for (int j = 0; j < 4; j++) feed(0, 8'h00, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule